// File: doc/BRIEF.md
# Configuration frame scrubber

The block walks a configuration memory one frame at a time and repairs single-bit upsets in it. For each frame it fetches 81 words of 32 bits (2,592 bits) through a word-serial request/acknowledge port. It keeps a copy of the frame in a local buffer and streams the same words to an external error-correction syndrome unit. When the syndrome unit reports a correctable error, the block inverts the reported bit in its buffer and writes the whole frame back to the address it came from. Frames without errors are never written.

A syndrome that is uncorrectable, or one that points outside the frame, leaves the frame untouched. In that case the frame address is logged and a sticky flag is raised so that a higher-level agent can start hard-error handling. The scan moves on frame by frame and wraps to frame zero after the last one.

Software can hold the scan with a pause input, which takes effect only between frames. Software can also read two saturating event counters, one for corrected frames and one for uncorrectable frames, and a clear input zeroes both counters together with the flag.

Top module: `cfg_scrubber`

## Requirements
- R1: After reset `req_o`, `busy_o` and `uncorr_flag_o` are 0, and `frame_o`, `corr_cnt_o` and `uncorr_cnt_o` are 0.
- R2: Each frame is read with `req_o`=1 and `we_o`=0 as `FRAME_WORDS` word transfers with `word_o` ascending from 0. Each acknowledged word is presented on `syn_data_o` with `syn_valid_o` one cycle later. `syn_first_o` marks word 0 and `syn_last_o` marks word `FRAME_WORDS`-1.
- R3: When the syndrome result (`syn_done_i`=1) has `syn_err_i`=0, no write transfer is issued for that frame.
- R4: When `syn_err_i`=1, `syn_uncorr_i`=0 and `syn_word_i`<`FRAME_WORDS`, bit `syn_bit_i` of word `syn_word_i` is inverted. The whole frame is then written back to the same frame address with `we_o`=1 and `word_o` ascending from 0, every other bit is unchanged, and `corr_cnt_o` increments.
- R5: When `syn_err_i`=1 and either `syn_uncorr_i`=1 or `syn_word_i`>=`FRAME_WORDS`, the frame is not written. `uncorr_frame_o` takes the frame address, `uncorr_flag_o` is set and stays set until cleared, and `uncorr_cnt_o` increments.
- R6: Frames are visited in the order 0, 1, ..., `NUM_FRAMES`-1 and then 0 again.
- R7: `pause_i` is sampled only between frames. A frame in progress finishes its read and any write-back, and no new frame starts while `pause_i`=1.
- R8: `clr_i`=1 zeroes both counters and `uncorr_flag_o` in the next cycle, and it takes priority over an increment in the same cycle.
- R9: While `req_o`=1 and `ack_i`=0, `req_o`, `we_o`, `frame_o`, `word_o` and `wdata_o` hold their values.
- R10: Each counter stops at its maximum value 2^`CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pause_i | input | 1 | Hold scanning at the next frame boundary |
| clr_i | input | 1 | Clear counters and uncorrectable flag |
| req_o | output | 1 | Access request, held until acknowledged |
| we_o | output | 1 | 1 = write transfer, 0 = read transfer |
| frame_o | output | FADDR_W | Frame address of the transfer |
| word_o | output | WIDX_W | Word index within the frame |
| wdata_o | output | WORD_W | Write data |
| ack_i | input | 1 | Transfer acknowledge; read data valid with it |
| rdata_i | input | WORD_W | Read data |
| syn_valid_o | output | 1 | Word strobe towards the syndrome unit |
| syn_first_o | output | 1 | Strobed word is word 0 |
| syn_last_o | output | 1 | Strobed word is the last word |
| syn_data_o | output | WORD_W | Word towards the syndrome unit |
| syn_done_i | input | 1 | Syndrome result valid (one-cycle pulse) |
| syn_err_i | input | 1 | Frame has an error |
| syn_uncorr_i | input | 1 | Error is not correctable |
| syn_word_i | input | WIDX_W | Word index of the erroneous bit |
| syn_bit_i | input | BIT_W | Bit index of the erroneous bit |
| busy_o | output | 1 | A frame is being processed |
| corr_cnt_o | output | CNT_W | Corrected-frame counter |
| uncorr_cnt_o | output | CNT_W | Uncorrectable-frame counter |
| uncorr_flag_o | output | 1 | Sticky uncorrectable-error flag |
| uncorr_frame_o | output | FADDR_W | Address of the last uncorrectable frame |

## Verification
Several properties are checked on every cycle: the request holds steady while it waits, the word index stays inside the frame, and writes appear only after a correctable syndrome in the current frame. The checks also cover the frame address advancing by one with wrap-around, a frame starting only while pause is low, the flag staying sticky, clear taking priority and the counters saturating. Only the bench scenarios can show that the right bit was repaired and every other bit survived the write-back. The same holds for clean and uncorrectable frames being left untouched, the logged address being the failing frame, a mid-frame pause letting the frame finish, and the counters matching the number of injected errors.

// File: rtl/cfg_scrub_pkg.sv
package cfg_scrub_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WAIT,
    S_PATCH,
    S_WRITE,
    S_NEXT
  } scrub_state_e;
endpackage

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl
  import cfg_scrub_pkg::*;
#(
  parameter int FRAME_WORDS = 81,
  parameter int NUM_FRAMES  = 16,
  parameter int WIDX_W      = 7,
  parameter int FADDR_W     = 4,
  parameter int BIT_W       = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pause_i,
  input  logic               ack_i,
  input  logic               syn_done_i,
  input  logic               syn_err_i,
  input  logic               syn_uncorr_i,
  input  logic [WIDX_W-1:0]  syn_word_i,
  input  logic [BIT_W-1:0]   syn_bit_i,
  output logic               req_o,
  output logic               we_o,
  output logic               busy_o,
  output logic               load_o,
  output logic               patch_o,
  output logic [FADDR_W-1:0] frame_o,
  output logic [WIDX_W-1:0]  word_o,
  output logic [WIDX_W-1:0]  patch_word_o,
  output logic [BIT_W-1:0]   patch_bit_o,
  output logic               corr_evt_o,
  output logic               uncorr_evt_o,
  output logic               syn_valid_o,
  output logic               syn_first_o,
  output logic               syn_last_o
);
  localparam logic [WIDX_W-1:0]  LAST_W = WIDX_W'(FRAME_WORDS - 1);
  localparam logic [FADDR_W-1:0] LAST_F = FADDR_W'(NUM_FRAMES - 1);

  scrub_state_e       state_q;
  logic [WIDX_W-1:0]  word_q;
  logic [FADDR_W-1:0] frame_q;
  logic [WIDX_W-1:0]  pw_q;
  logic [BIT_W-1:0]   pb_q;
  logic               sv_q, sf_q, sl_q;
  logic               last_word, bad_loc, decide, xfer;

  assign last_word    = (word_q == LAST_W);
  assign bad_loc      = syn_uncorr_i || (syn_word_i > LAST_W);
  assign decide       = (state_q == S_WAIT) && syn_done_i && syn_err_i;
  assign corr_evt_o   = decide && !bad_loc;
  assign uncorr_evt_o = decide && bad_loc;
  assign req_o        = (state_q == S_READ) || (state_q == S_WRITE);
  assign we_o         = (state_q == S_WRITE);
  assign busy_o       = (state_q != S_IDLE);
  assign xfer         = req_o && ack_i;
  assign load_o       = (state_q == S_READ) && ack_i;
  assign patch_o      = (state_q == S_PATCH);
  assign frame_o      = frame_q;
  assign word_o       = word_q;
  assign patch_word_o = pw_q;
  assign patch_bit_o  = pb_q;
  assign syn_valid_o  = sv_q;
  assign syn_first_o  = sf_q;
  assign syn_last_o   = sl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      frame_q <= '0;
      pw_q    <= '0;
      pb_q    <= '0;
      sv_q    <= 1'b0;
      sf_q    <= 1'b0;
      sl_q    <= 1'b0;
    end else begin
      sv_q <= load_o;
      sf_q <= load_o && (word_q == '0);
      sl_q <= load_o && last_word;
      unique case (state_q)
        S_IDLE: if (!pause_i) begin
          state_q <= S_READ;
          word_q  <= '0;
        end
        S_READ, S_WRITE: if (xfer) begin
          if (last_word) begin
            word_q  <= '0;
            state_q <= (state_q == S_READ) ? S_WAIT : S_NEXT;
          end else begin
            word_q <= word_q + 1'b1;
          end
        end
        S_WAIT: if (syn_done_i) begin
          if (corr_evt_o) begin
            pw_q    <= syn_word_i;
            pb_q    <= syn_bit_i;
            state_q <= S_PATCH;
          end else begin
            state_q <= S_NEXT;
          end
        end
        S_PATCH: begin
          word_q  <= '0;
          state_q <= S_WRITE;
        end
        S_NEXT: begin
          frame_q <= (frame_q == LAST_F) ? '0 : frame_q + 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_scrub_buf.sv
module cfg_scrub_buf #(
  parameter int FRAME_WORDS = 81,
  parameter int WORD_W      = 32,
  parameter int WIDX_W      = 7,
  parameter int BIT_W       = 5
) (
  input  logic              clk_i,
  input  logic              load_i,
  input  logic [WIDX_W-1:0] load_word_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              patch_i,
  input  logic [WIDX_W-1:0] patch_word_i,
  input  logic [BIT_W-1:0]  patch_bit_i,
  input  logic [WIDX_W-1:0] rd_word_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [FRAME_WORDS];

  always_ff @(posedge clk_i) begin
    if (load_i)
      mem_q[load_word_i] <= load_data_i;
    else if (patch_i)
      mem_q[patch_word_i][patch_bit_i] <= ~mem_q[patch_word_i][patch_bit_i];
  end

  assign rd_data_o = mem_q[rd_word_i];
endmodule

// File: rtl/cfg_scrub_stats.sv
module cfg_scrub_stats #(
  parameter int CNT_W   = 16,
  parameter int FADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               corr_evt_i,
  input  logic               uncorr_evt_i,
  input  logic [FADDR_W-1:0] frame_i,
  output logic [CNT_W-1:0]   corr_cnt_o,
  output logic [CNT_W-1:0]   uncorr_cnt_o,
  output logic               uncorr_flag_o,
  output logic [FADDR_W-1:0] uncorr_frame_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  logic [1:0]       evt;
  logic [CNT_W-1:0] cnt_q [2];

  assign evt = {uncorr_evt_i, corr_evt_i};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q[i] <= '0;
      else if (clr_i)                       cnt_q[i] <= '0;
      else if (evt[i] && cnt_q[i] != MAX_CNT) cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uncorr_flag_o  <= 1'b0;
      uncorr_frame_o <= '0;
    end else begin
      if (uncorr_evt_i) uncorr_frame_o <= frame_i;
      if (clr_i)             uncorr_flag_o <= 1'b0;
      else if (uncorr_evt_i) uncorr_flag_o <= 1'b1;
    end
  end

  assign corr_cnt_o   = cnt_q[0];
  assign uncorr_cnt_o = cnt_q[1];
endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 81,
  parameter int NUM_FRAMES  = 16,
  parameter int CNT_W       = 16,
  parameter int WIDX_W      = $clog2(FRAME_WORDS + 1),
  parameter int FADDR_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  parameter int BIT_W       = $clog2(WORD_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pause_i,
  input  logic               clr_i,
  output logic               req_o,
  output logic               we_o,
  output logic [FADDR_W-1:0] frame_o,
  output logic [WIDX_W-1:0]  word_o,
  output logic [WORD_W-1:0]  wdata_o,
  input  logic               ack_i,
  input  logic [WORD_W-1:0]  rdata_i,
  output logic               syn_valid_o,
  output logic               syn_first_o,
  output logic               syn_last_o,
  output logic [WORD_W-1:0]  syn_data_o,
  input  logic               syn_done_i,
  input  logic               syn_err_i,
  input  logic               syn_uncorr_i,
  input  logic [WIDX_W-1:0]  syn_word_i,
  input  logic [BIT_W-1:0]   syn_bit_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   corr_cnt_o,
  output logic [CNT_W-1:0]   uncorr_cnt_o,
  output logic               uncorr_flag_o,
  output logic [FADDR_W-1:0] uncorr_frame_o
);
  logic              load, patch, corr_evt, uncorr_evt;
  logic [WIDX_W-1:0] patch_word;
  logic [BIT_W-1:0]  patch_bit;
  logic [WORD_W-1:0] syn_data_q;

  cfg_scrub_ctrl #(
    .FRAME_WORDS(FRAME_WORDS), .NUM_FRAMES(NUM_FRAMES),
    .WIDX_W(WIDX_W), .FADDR_W(FADDR_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .pause_i, .ack_i,
    .syn_done_i, .syn_err_i, .syn_uncorr_i, .syn_word_i, .syn_bit_i,
    .req_o, .we_o, .busy_o,
    .load_o(load), .patch_o(patch),
    .frame_o, .word_o,
    .patch_word_o(patch_word), .patch_bit_o(patch_bit),
    .corr_evt_o(corr_evt), .uncorr_evt_o(uncorr_evt),
    .syn_valid_o, .syn_first_o, .syn_last_o
  );

  cfg_scrub_buf #(
    .FRAME_WORDS(FRAME_WORDS), .WORD_W(WORD_W), .WIDX_W(WIDX_W), .BIT_W(BIT_W)
  ) u_buf (
    .clk_i,
    .load_i(load), .load_word_i(word_o), .load_data_i(rdata_i),
    .patch_i(patch), .patch_word_i(patch_word), .patch_bit_i(patch_bit),
    .rd_word_i(word_o), .rd_data_o(wdata_o)
  );

  cfg_scrub_stats #(.CNT_W(CNT_W), .FADDR_W(FADDR_W)) u_stats (
    .clk_i, .rst_ni, .clr_i,
    .corr_evt_i(corr_evt), .uncorr_evt_i(uncorr_evt), .frame_i(frame_o),
    .corr_cnt_o, .uncorr_cnt_o, .uncorr_flag_o, .uncorr_frame_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   syn_data_q <= '0;
    else if (load) syn_data_q <= rdata_i;
  end
  assign syn_data_o = syn_data_q;
endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
  parameter int WORD_W      = 32,
  parameter int FRAME_WORDS = 81,
  parameter int NUM_FRAMES  = 16,
  parameter int CNT_W       = 16,
  parameter int WIDX_W      = 7,
  parameter int FADDR_W     = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pause_i,
  input logic               clr_i,
  input logic               req_o,
  input logic               we_o,
  input logic [FADDR_W-1:0] frame_o,
  input logic [WIDX_W-1:0]  word_o,
  input logic [WORD_W-1:0]  wdata_o,
  input logic               ack_i,
  input logic               syn_done_i,
  input logic               syn_err_i,
  input logic               syn_uncorr_i,
  input logic [WIDX_W-1:0]  syn_word_i,
  input logic [CNT_W-1:0]   corr_cnt_o,
  input logic [CNT_W-1:0]   uncorr_cnt_o,
  input logic               uncorr_flag_o
);
  localparam logic [FADDR_W-1:0] LAST_F  = FADDR_W'(NUM_FRAMES - 1);
  localparam logic [CNT_W-1:0]   MAX_CNT = '1;

  logic dirty_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dirty_q <= 1'b0;
    else if (syn_done_i && syn_err_i && !syn_uncorr_i &&
             (int'(syn_word_i) < FRAME_WORDS)) dirty_q <= 1'b1;
    else if (req_o && !we_o) dirty_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(we_o) && $stable(frame_o) &&
                        $stable(word_o) && $stable(wdata_o)); // R9
  AST_WORD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> int'(word_o) < FRAME_WORDS); // R2
  AST_WRITE_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o |-> dirty_q); // R3
  AST_FRAME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_o) |-> (frame_o == FADDR_W'($past(frame_o) + 1'b1)) ||
                          ($past(frame_o) == LAST_F && frame_o == '0)); // R6
  AST_PAUSE_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) && !we_o |-> !$past(pause_i)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_flag_o && !clr_i |=> uncorr_flag_o); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> corr_cnt_o == '0 && uncorr_cnt_o == '0 && !uncorr_flag_o); // R8
  AST_CORR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_cnt_o == MAX_CNT && !clr_i |=> corr_cnt_o == MAX_CNT); // R10
  AST_UNCORR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_cnt_o == MAX_CNT && !clr_i |=> uncorr_cnt_o == MAX_CNT); // R10
endmodule

bind cfg_scrubber cfg_scrubber_chk #(
  .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .NUM_FRAMES(NUM_FRAMES),
  .CNT_W(CNT_W), .WIDX_W(WIDX_W), .FADDR_W(FADDR_W)
) u_chk (.*);

// File: tb/cfg_scrubber_bench.sv
`timescale 1ns/1ps
module cfg_scrubber_bench;
  localparam int WW = 32, FW = 81, NF = 6, CW = 4;
  localparam int IW = 7, AW = 3, BW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, pause = 1'b1, clr = 1'b0;
  logic req, we, ack = 1'b0, syn_valid, syn_first, syn_last, busy, uflag;
  logic [AW-1:0] frame, uframe;
  logic [IW-1:0] word;
  logic [WW-1:0] wdata, rdata = '0, syn_data;
  logic syn_done = 1'b0, syn_err = 1'b0, syn_unc = 1'b0;
  logic [IW-1:0] syn_w = '0;
  logic [BW-1:0] syn_b = '0;
  logic [CW-1:0] ccnt, ucnt;

  cfg_scrubber #(.WORD_W(WW), .FRAME_WORDS(FW), .NUM_FRAMES(NF), .CNT_W(CW)) u_cfg_scrubber (
    .clk_i(clk), .rst_ni(rst_n), .pause_i(pause), .clr_i(clr),
    .req_o(req), .we_o(we), .frame_o(frame), .word_o(word), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata),
    .syn_valid_o(syn_valid), .syn_first_o(syn_first), .syn_last_o(syn_last),
    .syn_data_o(syn_data), .syn_done_i(syn_done), .syn_err_i(syn_err),
    .syn_uncorr_i(syn_unc), .syn_word_i(syn_w), .syn_bit_i(syn_b),
    .busy_o(busy), .corr_cnt_o(ccnt), .uncorr_cnt_o(ucnt),
    .uncorr_flag_o(uflag), .uncorr_frame_o(uframe));

  initial forever #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [WW-1:0] cfg_mem [NF][FW];
  logic [WW-1:0] gold    [NF][FW];
  int writes [NF];
  int starts = 0, last_rd_frame = -1, rd_frame = 0, rd_words = 0;
  int exp_rd_w = 0, exp_wr_w = 0;
  int rd_order_err = 0, wr_order_err = 0, wrap_err = 0, feed_err = 0;
  int bad_idx_frame = -1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int f = 0; f < NF; f++)
      for (int w = 0; w < FW; w++)
        if (cfg_mem[f][w] !== gold[f][w]) n++;
    return n;
  endfunction

  function automatic int total_writes();
    int n = 0;
    for (int f = 0; f < NF; f++) n += writes[f];
    return n;
  endfunction

  // memory stand-in: random 0..2 cycle acknowledge delay
  initial begin : mem_model
    int dly = 0;
    forever begin
      @(negedge clk);
      ack = 1'b0;
      if (rst_n && req) begin
        if (dly == 0) begin
          ack = 1'b1;
          if (we) begin
            if (int'(word) != exp_wr_w || int'(frame) != rd_frame) wr_order_err++;
            exp_wr_w = (int'(word) + 1) % FW;
            cfg_mem[frame][word] = wdata;
            writes[frame]++;
          end else begin
            if (int'(word) != exp_rd_w) rd_order_err++;
            exp_rd_w = (int'(word) + 1) % FW;
            if (word == '0) begin
              if (last_rd_frame >= 0 && int'(frame) != (last_rd_frame + 1) % NF) wrap_err++;
              last_rd_frame = int'(frame);
              rd_frame = int'(frame);
              rd_words = 0;
              exp_wr_w = 0;
              starts++;
            end
            rd_words++;
            rdata = cfg_mem[frame][word];
          end
          dly = int'($urandom % 3);
        end else begin
          dly--;
        end
      end
    end
  end

  // syndrome stand-in: compares the streamed frame against the golden copy
  initial begin : syn_model
    logic [WW-1:0] sbuf [FW];
    int idx = 0, pend = 0, nbits = 0, rw = 0, rb = 0;
    forever begin
      @(negedge clk);
      syn_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          syn_done = 1'b1;
          syn_err  = (nbits != 0);
          syn_unc  = (nbits > 1);
          syn_w    = (bad_idx_frame == rd_frame && nbits == 1) ? IW'(FW) : IW'(rw);
          syn_b    = BW'(rb);
        end
      end
      if (syn_valid) begin
        if (syn_first) idx = 0;
        if (idx < FW) sbuf[idx] = syn_data;
        idx++;
        if (syn_last) begin
          if (idx != FW) feed_err++;
          nbits = 0;
          for (int w = 0; w < FW; w++)
            for (int b = 0; b < WW; b++)
              if (sbuf[w][b] !== gold[rd_frame][w][b]) begin
                nbits++; rw = w; rb = b;
              end
          pend = 2;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wait_starts(input int n);
    int target = starts + n;
    while (starts < target) @(negedge clk);
  endtask

  task automatic hold_idle();
    pause = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_pass();
    pause = 1'b0;
    wait_starts(NF);
    hold_idle();
  endtask

  task automatic flip(input int f, input int w, input int b);
    cfg_mem[f][w][b] = ~cfg_mem[f][w][b];
  endtask

  task automatic clear_writes();
    for (int f = 0; f < NF; f++) writes[f] = 0;
  endtask

  initial begin : stim
    int expc, fr, wb_before, st_before;
    void'($urandom(32'd2024));
    for (int f = 0; f < NF; f++)
      for (int w = 0; w < FW; w++) begin
        gold[f][w] = $urandom;
        cfg_mem[f][w] = gold[f][w];
      end
    clear_writes();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req == 1'b0 && busy == 1'b0 && uflag == 1'b0, "R1 req/busy/flag", {req, busy, uflag}, 0);
    chk(frame == '0 && ccnt == '0 && ucnt == '0, "R1 frame/counters", {frame, ccnt, ucnt}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req == 1'b0 && busy == 1'b0, "R7 held by pause after reset", {req, busy}, 0);

    // clean pass
    run_pass();
    chk(total_writes() == 0, "R3 no write on clean memory", total_writes(), 0);
    chk(ccnt == 0 && ucnt == 0, "R3 counters after clean pass", {ccnt, ucnt}, 0);
    chk(rd_order_err == 0 && feed_err == 0, "R2 read order and feed", rd_order_err + feed_err, 0);

    // directed correctable errors, including first and last bit of a frame
    clear_writes();
    flip(1, 0, 0);
    flip(3, 37, 13);
    flip(4, FW - 1, WW - 1);
    run_pass();
    chk(mem_diff() == 0, "R4 memory repaired", mem_diff(), 0);
    chk(ccnt == 3, "R4 corrected count", ccnt, 3);
    chk(writes[1] == FW && writes[3] == FW && writes[4] == FW, "R4 whole frames written",
        writes[1] + writes[3] + writes[4], 3 * FW);
    chk(writes[0] == 0 && writes[2] == 0 && writes[5] == 0, "R3 clean frames untouched",
        writes[0] + writes[2] + writes[5], 0);
    chk(wr_order_err == 0, "R4 write order and address", wr_order_err, 0);

    // uncorrectable double error
    clear_writes();
    flip(2, 5, 1);
    flip(2, 60, 30);
    run_pass();
    chk(uflag == 1'b1, "R5 flag set", uflag, 1);
    chk(uframe == 3'd2, "R5 logged frame", uframe, 2);
    chk(ucnt == 1 && ccnt == 3, "R5 counters", {ucnt, ccnt}, {4'd1, 4'd3});
    chk(writes[2] == 0, "R5 no write-back", writes[2], 0);
    chk(mem_diff() == 2, "R5 frame left as is", mem_diff(), 2);
    flip(2, 5, 1);
    flip(2, 60, 30);

    // syndrome pointing beyond the frame is uncorrectable
    clear_writes();
    flip(5, 10, 7);
    bad_idx_frame = 5;
    run_pass();
    chk(writes[5] == 0, "R5 out-of-range index not written", writes[5], 0);
    chk(ucnt == 2 && uframe == 3'd5, "R5 out-of-range index logged", {ucnt, uframe}, {4'd2, 3'd5});
    chk(ccnt == 3, "R5 corrected count unchanged", ccnt, 3);
    bad_idx_frame = -1;
    flip(5, 10, 7);

    // clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk(ccnt == 0 && ucnt == 0 && uflag == 1'b0, "R8 clear", {ccnt, ucnt, uflag}, 0);

    // pause mid-frame with a write-back pending
    clear_writes();
    for (int f = 0; f < NF; f++) flip(f, 20, 3);
    pause = 1'b0;
    wait_starts(2);
    while (rd_words < 40) @(negedge clk);
    fr = rd_frame;
    hold_idle();
    chk(rd_words == FW, "R7 paused frame read completely", rd_words, FW);
    chk(writes[fr] == FW, "R7 paused frame written back", writes[fr], FW);
    chk(int'(frame) == (fr + 1) % NF, "R6 next frame after pause", frame, (fr + 1) % NF);
    wb_before = total_writes();
    st_before = starts;
    repeat (200) @(negedge clk);
    chk(starts == st_before && total_writes() == wb_before && !req, "R7 no activity while paused",
        starts - st_before, 0);
    expc = int'(ccnt);
    run_pass();
    expc += 4;

    // random rounds driving the counter into saturation
    for (int r = 0; r < 5; r++) begin
      for (int f = 0; f < NF; f++)
        if (r < 4 || ($urandom % 2) == 1) begin
          flip(f, int'($urandom % FW), int'($urandom % WW));
          expc++;
        end
      run_pass();
      chk(mem_diff() == 0, "R4 random round repaired", mem_diff(), 0);
      chk(int'(ccnt) == ((expc > CMAX) ? CMAX : expc), "R10 counter value", ccnt,
          (expc > CMAX) ? CMAX : expc);
    end
    chk(ccnt == CW'(CMAX), "R10 saturated", ccnt, CMAX);
    chk(wrap_err == 0, "R6 frame order with wrap", wrap_err, 0);
    chk(rd_order_err == 0 && wr_order_err == 0 && feed_err == 0, "R2 transfer order overall",
        rd_order_err + wr_order_err + feed_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule